// File: doc/BRIEF.md
# Interrupt Source Trigger and Pending Bank

This block holds the pending state of a bank of interrupt sources, 63 by default, inside one interrupt domain. Once per clock it looks at each raw input line and at that source's three-bit trigger mode. It decides whether the source has fired and sets the source's pending bit when it has. For edge detection it keeps a copy of each line's value from the previous evaluation.

The claim logic clears a pending bit with a one-cycle clear pulse. A per-source notify pulse tells the delivery logic that a source fired while its enable bit was set. A per-source error pulse flags a source that was evaluated under a reserved mode.

The domain's global enable freezes the whole bank while it is low: no pending bit is set and no stored input is updated. A source delegated to a child domain is frozen in the same way. The input lines are taken to be synchronous to the block clock. The asynchronous reset is released through a two-stage synchronizer inside the block.

Top module: `src_pending_bank`

## Requirements
- R1: After reset, all pending, notify and error outputs are 0, and every stored previous input is 0.
- R2: While `glb_en` is 0, no pending bit is set, no notify or error pulse is raised, and no stored previous input changes, whatever the input lines do.
- R3: A source whose `deleg_cfg` bit is 1 never sets pending, raises no notify or error pulse, and keeps its stored previous input.
- R4: Mode code 6 (level high) sets pending in a cycle where the line is 1. Mode code 7 (level low) sets pending in a cycle where the line is 0.
- R5: Mode code 4 (rising edge) sets pending when the line is 1 and the stored previous input is 0. Mode code 5 (falling edge) sets pending when the line is 0 and the stored previous input is 1.
- R6: Mode codes 0 (inactive) and 1 (detached) never set pending and never raise an error.
- R7: Mode codes 2 and 3 are reserved. Each evaluation of an active source under one of them raises that source's `mode_err_out` bit for one cycle and does not set pending.
- R8: For every source that is neither frozen nor delegated, the stored previous input takes the line value at every clock edge, whatever the mode.
- R9: `notify_out[i]` is 1 for the cycle after an edge at which source i set pending while `enable_cfg[i]` was 1. It is 0 otherwise.
- R10: A 1 on `clr_pend[i]` clears pending bit i at the next edge, even while the bank is frozen. If the source sets pending at the same edge, the set wins.
- R11: Each output is registered. Its effect appears in the cycle after the edge at which the inputs were sampled. Mode field i occupies bits [3i+2:3i] of `mode_cfg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| glb_en | input | 1 | Domain global enable; 0 freezes the bank |
| line_in | input | NSRC | Raw input lines, synchronous to clk |
| mode_cfg | input | 3*NSRC | Trigger mode per source, three bits each |
| deleg_cfg | input | NSRC | Source handed to a child domain |
| enable_cfg | input | NSRC | Per-source interrupt enable |
| clr_pend | input | NSRC | One-cycle clear of pending from the claim logic |
| pend_out | output | NSRC | Pending bits |
| notify_out | output | NSRC | One-cycle notify per source |
| mode_err_out | output | NSRC | One-cycle reserved-mode error per source |

## Verification
The assertions assume that every line value at a clock edge is a settled synchronous value. They also assume that the mode, delegate and enable fields are stable for the whole cycle. The frozen-bank checks rely on a clear pulse being the only way a pending bit may drop.

The bench drives all inputs at the falling edge, so every sampled value is settled before the rising edge. It changes modes and delegation only between cycles. A bench-side model built from the requirements predicts every output for each cycle. The stimulus uses directed sequences for each mode, freeze and clear corner case, followed by a long stretch of mixed random traffic.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic [2:0] {
    MODE_OFF    = 3'd0,
    MODE_DETACH = 3'd1,
    MODE_RSV_A  = 3'd2,
    MODE_RSV_B  = 3'd3,
    MODE_RISE   = 3'd4,
    MODE_FALL   = 3'd5,
    MODE_HIGH   = 3'd6,
    MODE_LOW    = 3'd7
  } trig_mode_e;

  typedef struct packed {
    logic fire;
    logic bad;
  } trig_res_t;

  localparam int unsigned MODE_W = 3;
endpackage

// File: rtl/trig_eval.sv
module trig_eval
  import trig_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic              cur,
  input  logic              prev,
  output trig_res_t         res
);
  trig_mode_e mode_e;
  assign mode_e = trig_mode_e'(mode);

  always_comb begin
    res = '0;
    unique case (mode_e)
      MODE_RISE:              res.fire = cur & ~prev;
      MODE_FALL:              res.fire = ~cur & prev;
      MODE_HIGH:              res.fire = cur;
      MODE_LOW:               res.fire = ~cur;
      MODE_RSV_A, MODE_RSV_B: res.bad  = 1'b1;
      default:                res      = '0;
    endcase
  end
endmodule

// File: rtl/trig_slice.sv
module trig_slice
  import trig_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              glb_en,
  input  logic              line,
  input  logic [MODE_W-1:0] mode,
  input  logic              deleg,
  input  logic              en,
  input  logic              clr,
  output logic              pend,
  output logic              notify,
  output logic              err
);
  trig_res_t res;
  logic      live;
  logic      pend_q, pend_d;
  logic      prev_q;
  logic      notify_q, notify_d;
  logic      err_q, err_d;

  trig_eval u_eval (
    .mode (mode),
    .cur  (line),
    .prev (prev_q),
    .res  (res)
  );

  always_comb begin
    live     = glb_en & ~deleg;
    pend_d   = (pend_q & ~clr) | (live & res.fire);
    notify_d = live & res.fire & en;
    err_d    = live & res.bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      notify_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      pend_q   <= pend_d;
      notify_q <= notify_d;
      err_q    <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else if (live) begin
      prev_q <= line;
    end
  end

  assign pend   = pend_q;
  assign notify = notify_q;
  assign err    = err_q;

  assert_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !clr) |=> ($stable(pend_q) && $stable(prev_q) && !notify_q && !err_q));

  assert_deleg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (deleg && !clr) |=> ($stable(pend_q) && $stable(prev_q) && !notify_q && !err_q));

  assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_OFF || mode == MODE_DETACH) && !pend_q) |=> (!pend_q && !err_q));

  assert_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> ($past(mode[2:1]) == 2'b01));

  assert_notify_R9: assert property (@(posedge clk) disable iff (!rst_n)
    notify_q |-> pend_q);

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !live) |=> !pend_q);
endmodule

// File: rtl/src_pending_bank.sv
module src_pending_bank
  import trig_pkg::*;
#(
  parameter int unsigned NSRC = 63
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   glb_en,
  input  logic [NSRC-1:0]        line_in,
  input  logic [MODE_W*NSRC-1:0] mode_cfg,
  input  logic [NSRC-1:0]        deleg_cfg,
  input  logic [NSRC-1:0]        enable_cfg,
  input  logic [NSRC-1:0]        clr_pend,
  output logic [NSRC-1:0]        pend_out,
  output logic [NSRC-1:0]        notify_out,
  output logic [NSRC-1:0]        mode_err_out
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[SYNC_STAGES-1];

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    trig_slice u_slice (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .glb_en (glb_en),
      .line   (line_in[i]),
      .mode   (mode_cfg[MODE_W*i +: MODE_W]),
      .deleg  (deleg_cfg[i]),
      .en     (enable_cfg[i]),
      .clr    (clr_pend[i]),
      .pend   (pend_out[i]),
      .notify (notify_out[i]),
      .err    (mode_err_out[i])
    );
  end

  assert_rst_R1: assert property (@(posedge clk)
    !rst_int_n |=> (pend_out == '0 || rst_int_n));
endmodule

// File: tb/sim_src_pending_bank.sv
`timescale 1ns/1ps
module sim_src_pending_bank;
  localparam int N = 63;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           glb_en;
  logic [N-1:0]   line_in, deleg_cfg, enable_cfg, clr_pend;
  logic [3*N-1:0] mode_cfg;
  logic [N-1:0]   pend_out, notify_out, mode_err_out;

  always #10 clk = ~clk;

  src_pending_bank #(.NSRC(N)) u0 (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .line_in(line_in),
    .mode_cfg(mode_cfg), .deleg_cfg(deleg_cfg), .enable_cfg(enable_cfg),
    .clr_pend(clr_pend), .pend_out(pend_out), .notify_out(notify_out),
    .mode_err_out(mode_err_out)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  logic [N-1:0] m_pend = '0;
  logic [N-1:0] m_prev = '0;

  logic [N-1:0] q_p[$], q_n[$], q_e[$];
  int           q_due[$];
  string        q_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic set_mode(input int i, input logic [2:0] m);
    mode_cfg[3*i +: 3] = m;
  endtask

  // driver: called at a falling edge after inputs are set
  task automatic tick(input string tag);
    logic [N-1:0] fire, bad;
    fire = '0;
    bad  = '0;
    for (int i = 0; i < N; i++) begin
      if (glb_en && !deleg_cfg[i]) begin
        case (mode_cfg[3*i +: 3])
          3'd4: fire[i] = line_in[i] & ~m_prev[i];
          3'd5: fire[i] = ~line_in[i] & m_prev[i];
          3'd6: fire[i] = line_in[i];
          3'd7: fire[i] = ~line_in[i];
          3'd2, 3'd3: bad[i] = 1'b1;
          default: ;
        endcase
        m_prev[i] = line_in[i];
      end
    end
    m_pend = (m_pend & ~clr_pend) | fire;
    q_p.push_back(m_pend);
    q_n.push_back(fire & enable_cfg);
    q_e.push_back(bad);
    q_due.push_back(cyc + 1);
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    while (q_due.size() > 0 && q_due[0] == cyc) begin
      logic [N-1:0] ep, en, ee;
      string t;
      ep = q_p.pop_front(); en = q_n.pop_front(); ee = q_e.pop_front();
      t = q_tag.pop_front();
      void'(q_due.pop_front());
      checks++;
      if (pend_out !== ep || notify_out !== en || mode_err_out !== ee) begin
        fails++;
        $display("FAIL %s: pend %h notify %h err %h, expected pend %h notify %h err %h",
                 t, pend_out, notify_out, mode_err_out, ep, en, ee);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; glb_en = 1'b1; line_in = '0; deleg_cfg = '0;
    enable_cfg = '1; clr_pend = '0; mode_cfg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (pend_out !== '0 || notify_out !== '0 || mode_err_out !== '0) begin
      fails++;
      $display("FAIL R1: pend %h notify %h err %h, expected all zero",
               pend_out, notify_out, mode_err_out);
    end

    // R4 level modes
    set_mode(1, 3'd6); set_mode(2, 3'd7);
    tick("R4 low fires");
    line_in[1] = 1'b1; line_in[2] = 1'b1;
    tick("R4 high fires");
    // R10 clear with set wins on source 1
    clr_pend[1] = 1'b1; clr_pend[2] = 1'b1;
    tick("R10 clear and set wins");
    clr_pend = '0;
    set_mode(1, 3'd0); set_mode(2, 3'd0);
    clr_pend[1] = 1'b1;
    tick("R10 clear");
    clr_pend = '0;

    // R5 edges
    set_mode(3, 3'd4); set_mode(4, 3'd5);
    tick("R5 setup");
    line_in[3] = 1'b1; line_in[4] = 1'b1;
    tick("R5 rise");
    line_in[3] = 1'b0; line_in[4] = 1'b0;
    tick("R5 fall");
    clr_pend[3] = 1'b1; clr_pend[4] = 1'b1;
    tick("R10 clear edges");
    clr_pend = '0;
    tick("R5 no edge held low");

    // R6 inactive and detached
    set_mode(5, 3'd0); set_mode(6, 3'd1);
    line_in[5] = 1'b1; line_in[6] = 1'b1;
    tick("R6 quiet high");
    line_in[6] = 1'b0;
    tick("R6 quiet low");

    // R8 stored input updates under inactive mode
    set_mode(5, 3'd4);
    tick("R8 no rise after inactive");

    // R7 reserved
    set_mode(7, 3'd2); set_mode(8, 3'd3); line_in[7] = 1'b1;
    tick("R7 reserved error");
    set_mode(7, 3'd0); set_mode(8, 3'd0);
    tick("R7 error clears");

    // R9 notify gated by enable
    enable_cfg[9] = 1'b0; set_mode(9, 3'd6); line_in[9] = 1'b1;
    tick("R9 no notify disabled");
    enable_cfg[9] = 1'b1; set_mode(9, 3'd0);
    tick("R9 no notify without fire");

    // R2 freeze
    set_mode(10, 3'd4); set_mode(11, 3'd4);
    line_in[11] = 1'b1;
    tick("R2 prep");
    glb_en = 1'b0;
    line_in[10] = 1'b1; line_in[11] = 1'b0;
    tick("R2 frozen");
    line_in[11] = 1'b1; set_mode(12, 3'd6); line_in[12] = 1'b1;
    clr_pend[3] = 1'b1;
    tick("R2 frozen with clear R10");
    clr_pend = '0;
    glb_en = 1'b1;
    tick("R2 resume against old input");

    // R3 delegation
    deleg_cfg[13] = 1'b1; set_mode(13, 3'd6); line_in[13] = 1'b1;
    deleg_cfg[14] = 1'b1; set_mode(14, 3'd4); line_in[14] = 1'b1;
    tick("R3 delegated");
    deleg_cfg[13] = 1'b0; deleg_cfg[14] = 1'b0;
    tick("R3 undelegated");

    // mixed random traffic
    for (int k = 0; k < 400; k++) begin
      line_in = {$urandom, $urandom};
      clr_pend = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      enable_cfg = {$urandom, $urandom} | {$urandom, $urandom};
      deleg_cfg = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      glb_en = ($urandom % 8) != 0;
      if (k % 16 == 0) mode_cfg = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      tick("mixed R2 R3 R4 R5 R6 R7 R8 R9 R10 R11");
    end
    line_in = '0; clr_pend = '0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule